// File: doc/BRIEF.md
# Event-Armed Delay Timer Channel

This block is one channel of a programmable delay generator. An accepted trigger loads a countdown from the 32-bit running delay. The countdown advances on a 1 µs tick strobe. On the tick that reaches terminal count, the channel raises its output for exactly one tick period. Software never writes the running delay directly. It writes the two 16-bit halves of a staged setting and then names a load event. The staged value is committed to the running delay when that event is seen on the event input.

If the load event arrives while a countdown is in progress, the commit is held back as pending and takes place on the first idle cycle afterwards. Two reserved load codes commit at once. A repeat flag makes every occurrence of the load event commit again. An inhibit aborts a countdown in progress and clears any waiting or pending commit. Event matching for the trigger, bus decoding and retained storage sit outside this block.

Top module: `evt_delay_chan`

## Requirements
- R1: A write with select 0 stores the low half and a write with select 1 stores the high half of the staged setting. Read select 2 returns the staged low half and select 3 the staged high half. Read selects 0 and 1 return the low and high halves of the running delay, which staged writes alone never change.
- R2: After an accepted trigger, the output rises on tick number max(D,2), where D is the running delay. A running delay of 0 or 1 therefore behaves as 2.
- R3: A write with select 2 carries the load code in bits 7:0 and the repeat flag in bit 15. It arms the channel (sets waiting) only if the channel is enabled and both halves have been written since the last arming. Otherwise the channel is not armed, though the code and repeat flag are still recorded.
- R4: When an event with the armed code arrives on an idle channel, the staged value is committed to the running delay. On a busy channel the event sets pending instead, leaves the running delay unchanged, and the commit happens on the first cycle after the countdown ends, which also clears pending.
- R5: Arming with code 0xFF or 0xFE commits without waiting for an event if the channel is idle; if it is busy, pending is set instead.
- R6: The output pulse stays high until the next tick strobe after timeout, so it is exactly one tick wide.
- R7: Staged writes made while waiting or pending are not lost: the commit copies the latest staged value.
- R8: With the repeat flag clear, an armed channel commits once and then drops waiting. With it set, waiting stays set and every matching event commits again.
- R9: An inhibit pulse disables the channel, aborts any countdown and output pulse, and clears waiting and pending. Afterwards, load events have no effect until the channel is enabled and armed again by a fresh write with select 2.
- R10: Read select 4 returns the status word: bit 0 enabled, bit 1 clock present, bit 2 pending, bit 3 waiting, bit 4 a load code has been written, bits 6:5 zero, bit 7 repeat flag, bits 15:8 last written load code. It is all zero after reset apart from the clock-present bit.
- R11: A trigger is ignored while a countdown is in progress or while the channel is disabled.
- R12: An enable pulse sets the enabled bit; after reset the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle 1 µs time-base strobe |
| clk_present_i | input | 1 | Time base present indication, shown in status |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write select: 0 low half, 1 high half, 2 load code |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 3 | Read select: 0/1 running, 2/3 staged, 4 status |
| rd_data_o | output | 16 | Read data for the selected register |
| enable_i | input | 1 | Enable pulse |
| inhibit_i | input | 1 | Inhibit/abort pulse |
| trig_i | input | 1 | Trigger event matched |
| evt_valid_i | input | 1 | An event code is present on evt_code_i |
| evt_code_i | input | 8 | Event code compared with the armed load code |
| pulse_o | output | 1 | Timeout pulse, one tick wide |

## Verification
The countdown is run with a delay of 5, with delays of 1 and 0, and with longer delays. Comparing the tick at which the output rises separates correct terminal counting from off-by-one counting and from a missing 2-tick floor. Commits are tried with an idle channel, with a busy channel, and with the immediate codes. Repeated events with the flag clear and with it set separate one-shot commits from repeat commits. A second trigger during a countdown, and triggers and events after an inhibit, are timed so that a restart or a stray commit would shift the pulse or change the running value that is read back.

// File: rtl/evt_delay_pkg.sv
package evt_delay_pkg;
  localparam int SEL_W     = 3;
  localparam int CODE_W    = 8;
  localparam int MIN_DELAY = 2;
  localparam logic [CODE_W-1:0] IMM_CODE_A = 8'hFF;
  localparam logic [CODE_W-1:0] IMM_CODE_B = 8'hFE;

  typedef enum logic [SEL_W-1:0] {
    WSEL_LO  = 3'd0,
    WSEL_HI  = 3'd1,
    WSEL_EVT = 3'd2
  } wsel_e;

  typedef enum logic [SEL_W-1:0] {
    RSEL_RUN_LO = 3'd0,
    RSEL_RUN_HI = 3'd1,
    RSEL_STG_LO = 3'd2,
    RSEL_STG_HI = 3'd3,
    RSEL_STAT   = 3'd4
  } rsel_e;
endpackage

// File: rtl/edc_rst_sync.sv
module edc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];
endmodule

// File: rtl/edc_setting.sv
module edc_setting
  import evt_delay_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int DLY_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              enable_i,
  input  logic              inhibit_i,
  input  logic              evt_valid_i,
  input  logic [CODE_W-1:0] evt_code_i,
  input  logic              busy_i,
  output logic [DLY_W-1:0]  shadow_o,
  output logic [DLY_W-1:0]  run_o,
  output logic              en_o,
  output logic              waiting_o,
  output logic              pending_o,
  output logic              repeat_o,
  output logic              code_wr_o,
  output logic [CODE_W-1:0] code_o
);
  logic [DLY_W-1:0]  shadow_q, shadow_d, run_q, run_d;
  logic              lo_ok_q, lo_ok_d, hi_ok_q, hi_ok_d;
  logic              waiting_q, waiting_d, pending_q, pending_d;
  logic              repeat_q, repeat_d, code_wr_q, code_wr_d;
  logic              en_q, en_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              commit, evt_hit, wr_code, imm;

  assign wr_code = wr_en_i && (wr_sel_i == WSEL_EVT);
  assign imm     = (wr_data_i[CODE_W-1:0] == IMM_CODE_A) ||
                   (wr_data_i[CODE_W-1:0] == IMM_CODE_B);
  assign evt_hit = evt_valid_i && waiting_q && en_q && (evt_code_i == code_q);

  always_comb begin
    shadow_d  = shadow_q;
    run_d     = run_q;
    lo_ok_d   = lo_ok_q;
    hi_ok_d   = hi_ok_q;
    waiting_d = waiting_q;
    pending_d = pending_q;
    repeat_d  = repeat_q;
    code_wr_d = code_wr_q;
    code_d    = code_q;
    en_d      = en_q;
    commit    = 1'b0;

    if (enable_i) en_d = 1'b1;

    if (wr_en_i && wr_sel_i == WSEL_LO) begin
      shadow_d[WORD_W-1:0] = wr_data_i;
      lo_ok_d = 1'b1;
    end
    if (wr_en_i && wr_sel_i == WSEL_HI) begin
      shadow_d[DLY_W-1:WORD_W] = wr_data_i;
      hi_ok_d = 1'b1;
    end

    // deferred commit once the countdown has ended
    if (pending_q && !busy_i) begin
      commit    = 1'b1;
      pending_d = 1'b0;
    end

    if (evt_hit) begin
      if (!repeat_q) waiting_d = 1'b0;
      if (busy_i) pending_d = 1'b1;
      else        commit    = 1'b1;
    end

    if (wr_code) begin
      code_wr_d = 1'b1;
      code_d    = wr_data_i[CODE_W-1:0];
      repeat_d  = wr_data_i[WORD_W-1];
      if (lo_ok_q && hi_ok_q && en_q) begin
        lo_ok_d = 1'b0;
        hi_ok_d = 1'b0;
        if (imm) begin
          waiting_d = 1'b0;
          if (busy_i) pending_d = 1'b1;
          else        commit    = 1'b1;
        end else begin
          waiting_d = 1'b1;
        end
      end
    end

    if (inhibit_i) begin
      en_d      = 1'b0;
      waiting_d = 1'b0;
      pending_d = 1'b0;
      commit    = 1'b0;
    end

    if (commit) run_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      run_q     <= '0;
      lo_ok_q   <= 1'b0;
      hi_ok_q   <= 1'b0;
      waiting_q <= 1'b0;
      pending_q <= 1'b0;
      repeat_q  <= 1'b0;
      code_wr_q <= 1'b0;
      code_q    <= '0;
      en_q      <= 1'b0;
    end else begin
      shadow_q  <= shadow_d;
      run_q     <= run_d;
      lo_ok_q   <= lo_ok_d;
      hi_ok_q   <= hi_ok_d;
      waiting_q <= waiting_d;
      pending_q <= pending_d;
      repeat_q  <= repeat_d;
      code_wr_q <= code_wr_d;
      code_q    <= code_d;
      en_q      <= en_d;
    end
  end

  assign shadow_o  = shadow_q;
  assign run_o     = run_q;
  assign en_o      = en_q;
  assign waiting_o = waiting_q;
  assign pending_o = pending_q;
  assign repeat_o  = repeat_q;
  assign code_wr_o = code_wr_q;
  assign code_o    = code_q;

  // R4: the running delay never moves while a countdown is in progress
  assert_run_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(run_q));
  // R9: inhibit drops enable, waiting and pending
  assert_inhibit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> (!en_q && !waiting_q && !pending_q));
  // R3: waiting is only ever raised by a load-code write
  assert_wait_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting_q) |-> $past(wr_en_i && wr_sel_i == WSEL_EVT));
endmodule

// File: rtl/edc_counter.sv
module edc_counter
  import evt_delay_pkg::*;
#(
  parameter int DLY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic             en_i,
  input  logic             inhibit_i,
  input  logic [DLY_W-1:0] run_i,
  output logic             busy_o,
  output logic             pulse_o
);
  localparam logic [DLY_W-1:0] FLOOR = DLY_W'(MIN_DELAY);

  logic [DLY_W-1:0] cnt_q, cnt_d, eff;
  logic             busy_q, busy_d, pulse_q, pulse_d;

  assign eff = (run_i < FLOOR) ? FLOOR : run_i;

  always_comb begin
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    pulse_d = pulse_q;
    if (inhibit_i) begin
      busy_d  = 1'b0;
      pulse_d = 1'b0;
    end else begin
      if (tick_i && pulse_q) pulse_d = 1'b0;
      if (busy_q) begin
        if (tick_i) begin
          if (cnt_q == DLY_W'(1)) begin
            busy_d  = 1'b0;
            pulse_d = 1'b1;
          end else begin
            cnt_d = cnt_q - DLY_W'(1);
          end
        end
      end else if (trig_i && en_i) begin
        busy_d = 1'b1;
        cnt_d  = eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      pulse_q <= pulse_d;
    end
  end

  assign busy_o  = busy_q;
  assign pulse_o = pulse_q;

  // R2: a running countdown never sits at zero
  assert_cnt_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));
  // R6: the pulse only starts at the end of a countdown
  assert_pulse_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(busy_q));
  // R9: inhibit aborts the countdown and the pulse
  assert_inhibit_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> (!busy_q && !pulse_q));
endmodule

// File: rtl/edc_readmux.sv
module edc_readmux
  import evt_delay_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int DLY_W = 2 * WORD_W
) (
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic [DLY_W-1:0]  run_i,
  input  logic [DLY_W-1:0]  shadow_i,
  input  logic              en_i,
  input  logic              clk_ok_i,
  input  logic              pending_i,
  input  logic              waiting_i,
  input  logic              code_wr_i,
  input  logic              repeat_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [15:0] stat;
  assign stat = {code_i, repeat_i, 2'b00, code_wr_i, waiting_i, pending_i, clk_ok_i, en_i};

  always_comb begin
    case (rd_sel_i)
      RSEL_RUN_LO: rd_data_o = run_i[WORD_W-1:0];
      RSEL_RUN_HI: rd_data_o = run_i[DLY_W-1:WORD_W];
      RSEL_STG_LO: rd_data_o = shadow_i[WORD_W-1:0];
      RSEL_STG_HI: rd_data_o = shadow_i[DLY_W-1:WORD_W];
      RSEL_STAT:   rd_data_o = WORD_W'(stat);
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_delay_chan.sv
module evt_delay_chan
  import evt_delay_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clk_present_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              enable_i,
  input  logic              inhibit_i,
  input  logic              trig_i,
  input  logic              evt_valid_i,
  input  logic [CODE_W-1:0] evt_code_i,
  output logic              pulse_o
);
  localparam int DLY_W = 2 * WORD_W;

  logic              srst_n, busy, en, waiting, pending, rpt, code_wr;
  logic [DLY_W-1:0]  shadow, run;
  logic [CODE_W-1:0] code;

  edc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  edc_setting #(.WORD_W(WORD_W)) u_set (
    .clk(clk), .rst_n(srst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .enable_i(enable_i), .inhibit_i(inhibit_i),
    .evt_valid_i(evt_valid_i), .evt_code_i(evt_code_i), .busy_i(busy),
    .shadow_o(shadow), .run_o(run), .en_o(en), .waiting_o(waiting),
    .pending_o(pending), .repeat_o(rpt), .code_wr_o(code_wr), .code_o(code)
  );

  edc_counter #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .tick_i(tick_i), .trig_i(trig_i), .en_i(en),
    .inhibit_i(inhibit_i), .run_i(run), .busy_o(busy), .pulse_o(pulse_o)
  );

  edc_readmux #(.WORD_W(WORD_W)) u_rd (
    .rd_sel_i(rd_sel_i), .run_i(run), .shadow_i(shadow), .en_i(en),
    .clk_ok_i(clk_present_i), .pending_i(pending), .waiting_i(waiting),
    .code_wr_i(code_wr), .repeat_i(rpt), .code_i(code), .rd_data_o(rd_data_o)
  );

  // R11: a trigger never disturbs a countdown already in progress
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !tick_i && !inhibit_i) |=> busy);
endmodule

// File: tb/evt_delay_chan_tb.sv
module evt_delay_chan_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, tick_i, clk_present_i, wr_en_i, enable_i, inhibit_i;
  logic        trig_i, evt_valid_i, pulse_o;
  logic [2:0]  wr_sel_i, rd_sel_i;
  logic [15:0] wr_data_i, rd_data_o;
  logic [7:0]  evt_code_i;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_delay_chan dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clk_present_i(clk_present_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .enable_i(enable_i),
    .inhibit_i(inhibit_i), .trig_i(trig_i), .evt_valid_i(evt_valid_i),
    .evt_code_i(evt_code_i), .pulse_o(pulse_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] val);
    rd_sel_i = sel; #1; val = rd_data_o;
  endtask

  task automatic chk_rd(string req, string what, logic [2:0] sel, logic [15:0] exp);
    logic [15:0] v;
    rd(sel, v);
    check(req, what, v, exp);
  endtask

  task automatic wr(logic [2:0] sel, logic [15:0] data);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic tick();
    tick_i = 1; @(negedge clk); tick_i = 0;
  endtask
  task automatic trig();
    trig_i = 1; @(negedge clk); trig_i = 0;
  endtask
  task automatic evt(logic [7:0] c);
    evt_valid_i = 1; evt_code_i = c; @(negedge clk); evt_valid_i = 0;
  endtask
  task automatic ena();
    enable_i = 1; @(negedge clk); enable_i = 0;
  endtask
  task automatic inh();
    inhibit_i = 1; @(negedge clk); inhibit_i = 0;
  endtask

  task automatic ticks_to_pulse(int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      tick();
      if (pulse_o) begin n = i; return; end
    end
  endtask

  task automatic t_reset();
    check("R10", "pulse after reset", pulse_o, 0);
    chk_rd("R10", "status after reset", 3'd4, 16'h0000);
    chk_rd("R1", "running low after reset", 3'd0, 16'h0000);
    clk_present_i = 1;
    chk_rd("R10", "clock present bit", 3'd4, 16'h0002);
    ena();
    chk_rd("R12", "enabled bit", 3'd4, 16'h0003);
  endtask

  task automatic t_arm();
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'h0023);
    chk_rd("R3", "no arm without high half", 3'd4, 16'h2313);
    wr(3'd1, 16'h0000);
    chk_rd("R1", "staged low", 3'd2, 16'h0005);
    chk_rd("R1", "staged high", 3'd3, 16'h0000);
    wr(3'd2, 16'h0023);
    chk_rd("R10", "waiting status", 3'd4, 16'h231B);
    chk_rd("R1", "running untouched by staging", 3'd0, 16'h0000);
  endtask

  task automatic t_load_idle();
    evt(8'h22);
    chk_rd("R4", "wrong event keeps waiting", 3'd4, 16'h231B);
    evt(8'h23);
    chk_rd("R4", "commit on idle event", 3'd0, 16'h0005);
    chk_rd("R8", "one-shot drops waiting", 3'd4, 16'h2313);
    wr(3'd0, 16'h0011);
    evt(8'h23);
    chk_rd("R8", "one-shot does not reload", 3'd0, 16'h0005);
    wr(3'd0, 16'h0005);
  endtask

  task automatic t_delay();
    int n;
    trig();
    ticks_to_pulse(20, n);
    check("R2", "pulse tick for delay 5", n, 5);
    repeat (3) @(negedge clk);
    check("R6", "pulse held between ticks", pulse_o, 1);
    tick();
    check("R6", "pulse ends at next tick", pulse_o, 0);
  endtask

  task automatic t_min();
    int n;
    wr(3'd0, 16'h0001); wr(3'd1, 16'h0000); wr(3'd2, 16'h00FF);
    chk_rd("R5", "immediate FF commit", 3'd0, 16'h0001);
    trig(); ticks_to_pulse(20, n);
    check("R2", "delay 1 behaves as 2", n, 2);
    tick();
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000); wr(3'd2, 16'h00FE);
    chk_rd("R5", "immediate FE commit", 3'd0, 16'h0000);
    trig(); ticks_to_pulse(20, n);
    check("R2", "delay 0 behaves as 2", n, 2);
    tick();
  endtask

  task automatic t_pending();
    int n;
    wr(3'd0, 16'h000A); wr(3'd1, 16'h0000); wr(3'd2, 16'h00FF);
    trig(); tick(); tick();
    wr(3'd0, 16'h0007); wr(3'd1, 16'h0000); wr(3'd2, 16'h0040);
    evt(8'h40);
    chk_rd("R4", "pending while busy", 3'd4, 16'h4017);
    chk_rd("R4", "running held while pending", 3'd0, 16'h000A);
    wr(3'd0, 16'h0009);
    trig();
    ticks_to_pulse(20, n);
    check("R11", "busy trigger ignored", n, 8);
    @(negedge clk);
    chk_rd("R7", "latest staged committed", 3'd0, 16'h0009);
    chk_rd("R4", "pending cleared", 3'd4, 16'h4013);
    tick();
  endtask

  task automatic t_repeat();
    wr(3'd0, 16'h0004); wr(3'd1, 16'h0000); wr(3'd2, 16'h8055);
    chk_rd("R10", "repeat status", 3'd4, 16'h559B);
    evt(8'h55);
    chk_rd("R8", "repeat first commit", 3'd0, 16'h0004);
    chk_rd("R8", "repeat keeps waiting", 3'd4, 16'h559B);
    wr(3'd0, 16'h0006);
    evt(8'h55);
    chk_rd("R8", "repeat second commit", 3'd0, 16'h0006);
  endtask

  task automatic t_inhibit();
    int n;
    trig(); tick(); tick();
    inh();
    chk_rd("R9", "inhibit status", 3'd4, 16'h5592);
    ticks_to_pulse(10, n);
    check("R9", "aborted countdown no pulse", n, 0);
    wr(3'd0, 16'h000C);
    evt(8'h55);
    chk_rd("R9", "event ignored when inhibited", 3'd0, 16'h0006);
    trig(); ticks_to_pulse(10, n);
    check("R11", "trigger ignored when disabled", n, 0);
    ena();
    evt(8'h55);
    chk_rd("R9", "event ignored before rearm", 3'd0, 16'h0006);
    wr(3'd1, 16'h0000); wr(3'd2, 16'h0055);
    evt(8'h55);
    chk_rd("R9", "rearm then commit", 3'd0, 16'h000C);
    trig(); ticks_to_pulse(20, n);
    check("R2", "pulse tick for delay 12", n, 12);
    tick();
  endtask

  task automatic t_wide();
    wr(3'd0, 16'hABCD); wr(3'd1, 16'h1234); wr(3'd2, 16'h00FF);
    chk_rd("R1", "running high word", 3'd1, 16'h1234);
    chk_rd("R1", "running low word", 3'd0, 16'hABCD);
  endtask

  initial begin
    rst_n = 0; tick_i = 0; clk_present_i = 0; wr_en_i = 0; wr_sel_i = 0;
    wr_data_i = 0; rd_sel_i = 0; enable_i = 0; inhibit_i = 0; trig_i = 0;
    evt_valid_i = 0; evt_code_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_arm();
    t_load_idle();
    t_delay();
    t_min();
    t_pending();
    t_repeat();
    t_inhibit();
    t_wide();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule